// File: doc/BRIEF.md
# Oscillator Beat Mixer and Audio Output Combiner

This block turns two pairs of free-running oscillator square waves into two beat signals and merges them into a single audio pad value. One pair sets the pitch, the other sets the loudness. Each pair is mixed in one of two ways, chosen by its own switch. The first way is a plain AND of the two oscillators. The second is a sampling flip-flop that captures the second oscillator whenever the first one rises. The volume beat is also brought out to a separate pin, so that a frequency-measurement stage can use it.

All four oscillator inputs are asynchronous to the system clock. Each one passes through a synchroniser chain of `SYNC_STAGES` flops. The sampling flip-flop runs on the system clock and finds the rising edge of the first oscillator by comparing successive synchronised samples. An output switch selects how the pad is formed. In AND mode the pad always drives the AND of the two beats. In three-state mode the pad drives when the two beats agree and floats when they differ. Floating is signalled by dropping a separate output-enable pin, and a pad cell outside the block does the actual tristating. The switches are static control pins and carry no handshake. No data stream crosses the block's edge, so it has no valid/ready interface and no back-pressure.

Top module: `beat_combiner_top`

## Requirements
- R1: While `rst` is high at a clock edge, every synchroniser flop, the edge-history flops and both sampling flip-flops clear to 0. After reset, `pitch_beat`=0, `vol_beat`=0, `pad_val`=0 and `pad_oe`=1.
- R2: With `pitch_sw`=0, `pitch_beat` equals the AND of the synchronised `pitch_osc_a` and `pitch_osc_b`. A level on an oscillator input that is sampled at clock edge n appears at the output after edge n+SYNC_STAGES-1, which is two edges of latency with the default setting.
- R3: With `pitch_sw`=1, `pitch_beat` is a register. At each clock edge where the synchronised `pitch_osc_a` is 1 and its value one edge earlier was 0, the register loads the synchronised `pitch_osc_b`. At every other edge it holds its value.
- R4: The volume pair (`vol_osc_a`, `vol_osc_b`, `vol_sw`) follows the same rules as R2 and R3, independently of the pitch pair. The result appears on `vol_beat`.
- R5: With `out_sw`=0, `pad_oe`=1 and `pad_val` = `pitch_beat` AND `vol_beat`.
- R6: With `out_sw`=1, the pad behaves as follows:
  - both beats 1: `pad_oe`=1 and `pad_val`=1.
  - both beats 0: `pad_oe`=1 and `pad_val`=0.
  - beats differ: `pad_oe`=0.
- R7: Each sampling register keeps running while its pair is in AND mode. Moving a switch from 0 to 1 at once shows the last value the register captured, with no extra cycle.
- R8: Whenever `pad_oe` is 0, `pad_val` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pitch_osc_a | input | 1 | Pitch oscillator one (edge source in sampling mode), asynchronous |
| pitch_osc_b | input | 1 | Pitch oscillator two (sampled data), asynchronous |
| vol_osc_a | input | 1 | Volume oscillator one, asynchronous |
| vol_osc_b | input | 1 | Volume oscillator two, asynchronous |
| pitch_sw | input | 1 | Pitch mix mode: 0 = AND, 1 = sampling flip-flop |
| vol_sw | input | 1 | Volume mix mode: 0 = AND, 1 = sampling flip-flop |
| out_sw | input | 1 | Output mode: 0 = AND, 1 = three-state resolution |
| pitch_beat | output | 1 | Pitch beat signal |
| vol_beat | output | 1 | Volume beat, for the measurement path |
| pad_val | output | 1 | Value to drive on the audio pad |
| pad_oe | output | 1 | Pad output enable; 0 means float |

## Verification
The bound checker tests the output combiner against the two beat pins on every cycle. It confirms that AND mode always drives, that disagreement in three-state mode drops the enable, and that a floated pad carries 0. A counter-based property confirms that a beat in sampling mode stays frozen while its edge oscillator has been quiet for longer than the synchroniser depth. The exact latency through the synchronisers, which value is captured on which edge, and the carry-over of the captured value when a switch changes mode can only be shown by the bench's reference model. That model follows the input history edge by edge. Directed scenarios cover the mode-switch carry-over and a reset taken in the middle of a run.

// File: rtl/beat_pkg.sv
package beat_pkg;

  typedef enum logic {
    MIX_AND    = 1'b0,
    MIX_SAMPLE = 1'b1
  } mix_mode_e;

  typedef enum logic {
    OUT_AND  = 1'b0,
    OUT_TRI3 = 1'b1
  } out_mode_e;

  typedef struct packed {
    logic edge_src;
    logic data_src;
  } osc_pair_t;

endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_in[g];
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_in[g]};
      end
    end

    assign sync_out[g] = chain_q[LAST];
  end

endmodule

// File: rtl/pair_mixer.sv
module pair_mixer
  import beat_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  mix_mode_e mode,
  input  osc_pair_t osc,
  output logic      beat
);

  logic edge_prev_q;
  logic capture_q;
  logic edge_rise;
  logic and_beat;

  assign edge_rise = osc.edge_src & ~edge_prev_q;
  assign and_beat  = osc.edge_src & osc.data_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_prev_q <= 1'b0;
      capture_q   <= 1'b0;
    end else begin
      edge_prev_q <= osc.edge_src;
      if (edge_rise) capture_q <= osc.data_src;
    end
  end

  always_comb begin
    unique case (mode)
      MIX_AND:    beat = and_beat;
      MIX_SAMPLE: beat = capture_q;
      default:    beat = 1'b0;
    endcase
  end

endmodule

// File: rtl/out_combiner.sv
module out_combiner
  import beat_pkg::*;
(
  input  out_mode_e mode,
  input  logic      pitch,
  input  logic      vol,
  output logic      pad_val,
  output logic      pad_oe
);

  logic agree;

  assign agree = ~(pitch ^ vol);

  always_comb begin
    pad_val = pitch & vol;
    pad_oe  = 1'b1;
    unique case (mode)
      OUT_AND:  pad_oe = 1'b1;
      OUT_TRI3: pad_oe = agree;
      default:  pad_oe = 1'b1;
    endcase
  end

endmodule

// File: rtl/beat_combiner_top.sv
module beat_combiner_top
  import beat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pitch_osc_a,
  input  logic pitch_osc_b,
  input  logic vol_osc_a,
  input  logic vol_osc_b,
  input  logic pitch_sw,
  input  logic vol_sw,
  input  logic out_sw,
  output logic pitch_beat,
  output logic vol_beat,
  output logic pad_val,
  output logic pad_oe
);

  localparam int NUM_PAIRS = 2;
  localparam int NUM_OSC   = 2 * NUM_PAIRS;

  logic [NUM_OSC-1:0]   osc_raw;
  logic [NUM_OSC-1:0]   osc_sync_w;
  logic [NUM_PAIRS-1:0] mode_bits;
  logic [NUM_PAIRS-1:0] beats;

  assign osc_raw   = {vol_osc_b, vol_osc_a, pitch_osc_b, pitch_osc_a};
  assign mode_bits = {vol_sw, pitch_sw};

  osc_sync #(
    .WIDTH  (NUM_OSC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (osc_raw),
    .sync_out (osc_sync_w)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    osc_pair_t pair_in;
    assign pair_in.edge_src = osc_sync_w[2*p];
    assign pair_in.data_src = osc_sync_w[2*p+1];

    pair_mixer u_mix (
      .clk  (clk),
      .rst  (rst),
      .mode (mix_mode_e'(mode_bits[p])),
      .osc  (pair_in),
      .beat (beats[p])
    );
  end

  assign pitch_beat = beats[0];
  assign vol_beat   = beats[1];

  out_combiner u_out (
    .mode    (out_mode_e'(out_sw)),
    .pitch   (beats[0]),
    .vol     (beats[1]),
    .pad_val (pad_val),
    .pad_oe  (pad_oe)
  );

endmodule

// File: rtl/beat_combiner_chk.sv
module beat_combiner_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic pitch_osc_a,
  input logic vol_osc_a,
  input logic pitch_sw,
  input logic vol_sw,
  input logic out_sw,
  input logic pitch_beat,
  input logic vol_beat,
  input logic pad_val,
  input logic pad_oe
);

  localparam int QUIET = SYNC_STAGES + 2;
  localparam int CW    = $clog2(QUIET + 2);

  logic [CW-1:0] p_quiet, v_quiet;
  logic          p_last, v_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_quiet <= '0;
      v_quiet <= '0;
      p_last  <= 1'b0;
      v_last  <= 1'b0;
    end else begin
      p_last <= pitch_osc_a;
      v_last <= vol_osc_a;
      if (pitch_osc_a != p_last) p_quiet <= '0;
      else if (p_quiet < CW'(QUIET)) p_quiet <= p_quiet + 1'b1;
      if (vol_osc_a != v_last) v_quiet <= '0;
      else if (v_quiet < CW'(QUIET)) v_quiet <= v_quiet + 1'b1;
    end
  end

  assert_and_drives_R5: assert property (@(posedge clk) disable iff (rst)
    !out_sw |-> (pad_oe && pad_val == (pitch_beat & vol_beat)));

  assert_disagree_floats_R6: assert property (@(posedge clk) disable iff (rst)
    (out_sw && pitch_beat != vol_beat) |-> !pad_oe);

  assert_agree_drives_R6: assert property (@(posedge clk) disable iff (rst)
    (out_sw && pitch_beat == vol_beat) |-> (pad_oe && pad_val == pitch_beat));

  assert_float_low_R8: assert property (@(posedge clk) disable iff (rst)
    !pad_oe |-> !pad_val);

  assert_pitch_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (pitch_sw && $past(pitch_sw) && p_quiet >= CW'(QUIET)) |-> $stable(pitch_beat));

  assert_vol_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (vol_sw && $past(vol_sw) && v_quiet >= CW'(QUIET)) |-> $stable(vol_beat));

endmodule

bind beat_combiner_top beat_combiner_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pitch_osc_a (pitch_osc_a),
  .vol_osc_a   (vol_osc_a),
  .pitch_sw    (pitch_sw),
  .vol_sw      (vol_sw),
  .out_sw      (out_sw),
  .pitch_beat  (pitch_beat),
  .vol_beat    (vol_beat),
  .pad_val     (pad_val),
  .pad_oe      (pad_oe)
);

// File: tb/sim_beat_combiner_top.sv
`timescale 1ns/1ps
module sim_beat_combiner_top;

  localparam int SYNC = 2;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic pa = 0, pb = 0, va = 0, vb = 0;
  logic pitch_sw = 0, vol_sw = 0, out_sw = 0;
  logic pitch_beat, vol_beat, pad_val, pad_oe;

  beat_combiner_top #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst),
    .pitch_osc_a(pa), .pitch_osc_b(pb), .vol_osc_a(va), .vol_osc_b(vb),
    .pitch_sw(pitch_sw), .vol_sw(vol_sw), .out_sw(out_sw),
    .pitch_beat(pitch_beat), .vol_beat(vol_beat),
    .pad_val(pad_val), .pad_oe(pad_oe)
  );

  int total = 0, bad = 0, cycles = 0;
  bit armed = 0, done = 0;

  // Reference: history of sampled inputs, newest first; bit0 pa, bit1 pb, bit2 va, bit3 vb
  logic [3:0] hist[$];
  logic qp = 0, qv = 0;

  initial begin
    for (int i = 0; i <= SYNC; i++) hist.push_back(4'b0);
  end

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      hist = {};
      for (int i = 0; i <= SYNC; i++) hist.push_back(4'b0);
      qp = 0;
      qv = 0;
      armed = 1;
    end else begin
      if (hist[SYNC-1][0] && !hist[SYNC][0]) qp = hist[SYNC-1][1];
      if (hist[SYNC-1][2] && !hist[SYNC][2]) qv = hist[SYNC-1][3];
      hist.push_front({vb, va, pb, pa});
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_pitch();
    logic [3:0] s = hist[SYNC-1];
    return pitch_sw ? qp : (s[0] & s[1]);
  endfunction

  function automatic logic exp_vol();
    logic [3:0] s = hist[SYNC-1];
    return vol_sw ? qv : (s[2] & s[3]);
  endfunction

  // Per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      logic ep, ev, eoe, eval;
      ep   = exp_pitch();
      ev   = exp_vol();
      eoe  = out_sw ? (ep == ev) : 1'b1;
      eval = ep & ev;
      chk(pitch_sw ? "R3 pitch sample" : "R2 pitch and", pitch_beat, ep);
      chk("R4 volume beat", vol_beat, ev);
      chk(out_sw ? "R6 pad enable" : "R5 pad enable", pad_oe, eoe);
      chk(eoe ? (out_sw ? "R6 pad value" : "R5 pad value") : "R8 floated value", pad_val, eval);
    end
  end

  task automatic drive(logic [3:0] o);
    {vb, va, pb, pa} = o;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    rst = 1;
    step(3);
    rst = 0;
    @(negedge clk);
    // R1: state right after reset
    chk("R1 pitch_beat", pitch_beat, 1'b0);
    chk("R1 vol_beat", vol_beat, 1'b0);
    chk("R1 pad_oe", pad_oe, 1'b1);
    chk("R1 pad_val", pad_val, 1'b0);
    #1;

    // R2 latency: both pitch oscillators high, beat appears after SYNC edges
    drive(4'b0011);
    @(negedge clk);
    chk("R2 not yet visible", pitch_beat, 1'b0);
    @(negedge clk);
    chk("R2 visible after sync", pitch_beat, 1'b1);
    #1;

    // R2/R4/R5: AND modes, random oscillators
    for (int i = 0; i < 300; i++) begin
      drive(4'($urandom));
      step(1);
    end

    // R3/R4: sampling modes, slowly toggling oscillators
    pitch_sw = 1;
    vol_sw = 1;
    for (int i = 0; i < 600; i++) begin
      logic [3:0] o = {vb, va, pb, pa};
      for (int b = 0; b < 4; b++) if ($urandom_range(0, 3) == 0) o[b] = ~o[b];
      drive(o);
      step(1);
    end

    // R6/R8: three-state output with mixed modes
    out_sw = 1;
    for (int i = 0; i < 800; i++) begin
      if ($urandom_range(0, 15) == 0) pitch_sw = ~pitch_sw;
      if ($urandom_range(0, 15) == 0) vol_sw = ~vol_sw;
      drive(4'($urandom));
      step(1);
    end

    // R6 directed: pitch high, volume low -> floated
    pitch_sw = 0;
    vol_sw = 0;
    drive(4'b0011);
    step(SYNC + 1);
    chk("R6 disagree floats", pad_oe, 1'b0);
    chk("R8 floated drives 0", pad_val, 1'b0);
    drive(4'b1111);
    step(SYNC + 1);
    chk("R6 both high drives 1", pad_val, 1'b1);
    chk("R6 both high enabled", pad_oe, 1'b1);

    // R7: capture while in AND mode, then switch mode
    out_sw = 0;
    drive(4'b0010);
    step(5);
    drive(4'b0011);
    step(5);
    drive(4'b0001);
    step(5);
    chk("R7 AND beat low before switch", pitch_beat, 1'b0);
    pitch_sw = 1;
    @(negedge clk);
    chk("R7 captured value shown at once", pitch_beat, 1'b1);
    #1;

    // R1: reset in the middle of a run clears the sampling registers
    vol_sw = 1;
    drive(4'b1111);
    step(6);
    rst = 1;
    step(2);
    rst = 0;
    drive(4'b0000);
    @(negedge clk);
    chk("R1 pitch cleared by reset", pitch_beat, 1'b0);
    chk("R1 vol cleared by reset", vol_beat, 1'b0);
    #1;
    step(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cycles > WATCHDOG) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule